// File: doc/BRIEF.md
# Level-Interrupt End-of-Service Controller with Storm Throttling

This block is the end-of-interrupt path of an interrupt redirection unit. It holds a table of per-pin redirection entries and samples one pending-request line per pin into a register. An end-of-interrupt notice names a vector and arrives on a valid/ready stream. The block then walks the whole table, one entry per clock. For each level-triggered entry that carries that vector and is still awaiting acknowledgement, it clears the acknowledgement-wait flag. If the pin is still pending and unmasked, it asks for a new service pass.

Software that fails to quiet a level source causes back-to-back re-deliveries. The block counts these per vector. When a vector's count reaches a threshold, the count restarts from zero and the block does not request service at once. It arms a one-shot timer instead, and the timer issues the service pass later. A service pass is a one-cycle pulse on `service_req`. Requests from the scan and from the timer that fall in the same cycle give a single pulse.

The notice stream transfers when `eoi_valid` and `eoi_ready` are both high at a rising edge. `eoi_ready` is low for the whole scan, so a sender must hold its notice, with the vector unchanged, until ready returns. A plain table write port and a combinational read port stand in for the register file that sits outside this block.

Top module: `eoi_storm_ctl`

## Requirements
- R1: After synchronous active-high reset, every table entry reads 0x10000, which is masked (bit 16) with every other bit 0. `service_req` and `busy` are 0 and `eoi_ready` is 1. All counters and the timer start cleared, so a vector needs THRESH deliveries before its first deferral.
- R2: During the scan for vector V, an entry is acted on only when its bits [7:0] equal V, bit 15 (level trigger) is 1 and bit 14 (awaiting acknowledgement) is 1. Any other entry keeps its value, causes no pulse and leaves the counters unchanged.
- R3: An entry that is acted on has bit 14 cleared in the table. All its other bits keep their values.
- R4: An acted-on entry that is unmasked (bit 16 = 0) and whose pin's pending bit is set adds one to the counter of V. If the new count is below THRESH, `service_req` is high for the one cycle right after that entry's scan slot.
- R5: When the new count reaches THRESH, the counter of V returns to 0 and no immediate pulse is given. The timer is armed, and the pulse comes DELAY cycles later than the immediate pulse would have.
- R6: An acted-on entry that is masked, or whose pin is not pending, sets the counter of V to 0.
- R7: Arming the timer while it is already armed keeps the earlier expiry. Each expiry gives exactly one pulse and then disarms the timer.
- R8: An immediate request and a timer expiry that fall in the same cycle give one pulse of one cycle.
- R9: A notice is accepted at the rising edge where `eoi_valid` and `eoi_ready` are both high. In the cycle after acceptance, entry 0 is processed; index k is processed k cycles later. `busy` is high and `eoi_ready` is low for NPINS cycles.
- R10: Table writes are ignored while a scan is in progress. Writes whose index is NPINS or more are also ignored.
- R11: Each vector has its own counter. Deliveries on one vector do not move another vector toward deferral.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eoi_valid | input | 1 | End-of-interrupt notice present |
| eoi_ready | output | 1 | Block can take a notice (no scan running) |
| eoi_vector | input | 8 | Vector named by the notice |
| pend_in | input | NPINS | Per-pin pending request lines, registered each cycle |
| tbl_we | input | 1 | Table write strobe |
| tbl_widx | input | clog2(NPINS) | Table write index |
| tbl_wdata | input | 17 | Entry value: [7:0] vector, 14 awaiting ack, 15 level, 16 mask |
| tbl_ridx | input | clog2(NPINS) | Table read index |
| tbl_rdata | output | 17 | Entry at tbl_ridx, 0 when out of range |
| busy | output | 1 | Scan in progress |
| service_req | output | 1 | One-cycle request for a service pass |

## Verification
An immediate re-delivery from the scan and the expiry of the deferral timer can land on the same clock edge. The bench sets this up on purpose. It drives one vector into deferral from a known entry, then counts cycles and starts a second notice so that an immediate entry's slot falls exactly on the computed expiry edge. The bench model predicts `service_req` at every cycle. It judges the coincidence by requiring one high cycle at that edge with the neighbouring cycles low, and it confirms that the merged edge was actually reached.

// File: rtl/eoi_pkg.sv
`timescale 1ns/1ps
package eoi_pkg;
  localparam int VEC_W = 8;
  localparam int ENT_W = 17;

  typedef struct packed {
    logic             mask;
    logic             level;
    logic             rirr;
    logic [5:0]       rsvd;
    logic [VEC_W-1:0] vec;
  } entry_t;

  localparam logic [ENT_W-1:0] RST_BITS = 17'h10000;
endpackage

// File: rtl/eoi_table.sv
`timescale 1ns/1ps
module eoi_table
  import eoi_pkg::*;
#(
  parameter int N = 24,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  entry_t        wr_data,
  input  logic [IW-1:0] scan_idx,
  output entry_t        scan_entry,
  input  logic          scan_we,
  input  entry_t        scan_wdata,
  input  logic [IW-1:0] rd_idx,
  output entry_t        rd_data
);
  entry_t ents [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    entry_t q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= entry_t'(RST_BITS);
      end else if (scan_we && scan_idx == IW'(i)) begin
        q <= scan_wdata;
      end else if (wr_en && !lock && wr_idx == IW'(i)) begin
        q <= wr_data;
      end
    end
    assign ents[i] = q;
  end

  always_comb begin
    scan_entry = ents[0];
    rd_data    = '0;
    for (int i = 0; i < N; i++) begin
      if (scan_idx == IW'(i)) scan_entry = ents[i];
      if (rd_idx == IW'(i))   rd_data    = ents[i];
    end
  end

  // R3: the entry written by the scan no longer awaits acknowledgement
  p_scan_clears_rirr_r3: assert property (@(posedge clk) disable iff (rst)
    $past(scan_we) |-> !ents[$past(scan_idx)].rirr);

  // R10: with the table locked and no scan write, a steady read stays steady
  p_locked_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (lock && !scan_we) |=> (!$stable(rd_idx) || $stable(rd_data)));
endmodule

// File: rtl/eoi_scan.sv
`timescale 1ns/1ps
module eoi_scan
  import eoi_pkg::*;
#(
  parameter int N      = 24,
  parameter int THRESH = 10000,
  localparam int IW    = $clog2(N),
  localparam int NVEC  = 1 << VEC_W,
  localparam int CW    = $clog2(THRESH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eoi_valid,
  output logic             eoi_ready,
  input  logic [VEC_W-1:0] eoi_vec,
  input  logic [N-1:0]     pend,
  output logic             busy,
  output logic [IW-1:0]    scan_idx,
  input  entry_t           scan_entry,
  output logic             scan_we,
  output entry_t           scan_wdata,
  output logic             imm_req,
  output logic             arm_req
);
  localparam logic [CW-1:0] THR_C = CW'(THRESH);

  logic             busy_q;
  logic [IW-1:0]    idx_q;
  logic [VEC_W-1:0] vec_q;
  logic [CW-1:0]    cnt [NVEC];

  logic          accept, consider, act, deliver, storm;
  logic [CW-1:0] cnt_cur, cnt_inc;

  assign eoi_ready = !busy_q;
  assign accept    = eoi_valid && eoi_ready;
  assign busy      = busy_q;
  assign scan_idx  = idx_q;

  always_comb begin
    consider   = busy_q && scan_entry.level && (scan_entry.vec == vec_q);
    act        = consider && scan_entry.rirr;
    deliver    = act && !scan_entry.mask && pend[idx_q];
    cnt_cur    = cnt[vec_q];
    cnt_inc    = cnt_cur + CW'(1);
    storm      = deliver && (cnt_inc >= THR_C);
    imm_req    = deliver && !storm;
    arm_req    = storm;
    scan_we    = act;
    scan_wdata = scan_entry;
    scan_wdata.rirr = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      vec_q  <= '0;
      for (int v = 0; v < NVEC; v++) cnt[v] <= '0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        vec_q  <= eoi_vec;
      end else if (busy_q) begin
        if (idx_q == IW'(N - 1)) busy_q <= 1'b0;
        else                     idx_q  <= idx_q + IW'(1);
      end
      if (act) begin
        if (deliver && !storm) cnt[vec_q] <= cnt_inc;
        else                   cnt[vec_q] <= '0;
      end
    end
  end

  // R9: a notice taken at one edge blocks the next at the following edge
  p_no_back_to_back_r9: assert property (@(posedge clk) disable iff (rst)
    $past(eoi_valid && eoi_ready) |-> !eoi_ready);

  // R2: nothing is touched and nothing requested outside a scan
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !(scan_we || imm_req || arm_req));

  // R5: a counter never holds the threshold value between scan slots
  p_cnt_below_thresh_r5: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt[vec_q] < THR_C));

  // R6: a non-delivering acted-on entry leaves the counter at zero
  p_cnt_cleared_r6: assert property (@(posedge clk) disable iff (rst)
    (act && !deliver) |=> (cnt[$past(vec_q)] == '0));
endmodule

// File: rtl/eoi_timer.sv
`timescale 1ns/1ps
module eoi_timer #(
  parameter int DELAY = 1000000,
  localparam int TW   = $clog2(DELAY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic expire
);
  localparam logic [TW-1:0] DLY_C = TW'(DELAY);

  logic          armed_q;
  logic [TW-1:0] left_q, left_nxt;

  assign expire   = armed_q && (left_q == TW'(1));
  assign left_nxt = left_q - TW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      left_q  <= '0;
    end else if (arm) begin
      armed_q <= 1'b1;
      if (!armed_q || expire) left_q <= DLY_C;
      else                    left_q <= (left_nxt < DLY_C) ? left_nxt : DLY_C;
    end else if (armed_q) begin
      if (expire) armed_q <= 1'b0;
      left_q <= left_nxt;
    end
  end

  // R5: an arm request always leaves the timer armed
  p_arm_takes_r5: assert property (@(posedge clk) disable iff (rst)
    arm |=> armed_q);

  // R7: the remaining time of an armed timer stays inside one window
  p_left_bound_r7: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (left_q >= TW'(1) && left_q <= DLY_C));

  // R7: an expiry without a new arm disarms the timer
  p_expire_drops_r7: assert property (@(posedge clk) disable iff (rst)
    (expire && !arm) |=> !armed_q);
endmodule

// File: rtl/eoi_storm_ctl.sv
`timescale 1ns/1ps
module eoi_storm_ctl
  import eoi_pkg::*;
#(
  parameter int NPINS  = 24,
  parameter int THRESH = 10000,
  parameter int DELAY  = 1000000,
  localparam int IW    = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eoi_valid,
  output logic             eoi_ready,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic [NPINS-1:0] pend_in,
  input  logic             tbl_we,
  input  logic [IW-1:0]    tbl_widx,
  input  logic [ENT_W-1:0] tbl_wdata,
  input  logic [IW-1:0]    tbl_ridx,
  output logic [ENT_W-1:0] tbl_rdata,
  output logic             busy,
  output logic             service_req
);
  logic [NPINS-1:0] pend_q;
  logic             svc_q;
  logic [IW-1:0]    scan_idx;
  entry_t           scan_entry, scan_wdata, rd_ent;
  logic             scan_we, imm_req, arm_req, tmr_expire, busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      svc_q  <= 1'b0;
    end else begin
      pend_q <= pend_in;
      svc_q  <= imm_req || tmr_expire;
    end
  end

  assign service_req = svc_q;
  assign busy        = busy_i;
  assign tbl_rdata   = rd_ent;

  eoi_table #(.N(NPINS)) u_table (
    .clk        (clk),
    .rst        (rst),
    .lock       (busy_i),
    .wr_en      (tbl_we),
    .wr_idx     (tbl_widx),
    .wr_data    (entry_t'(tbl_wdata)),
    .scan_idx   (scan_idx),
    .scan_entry (scan_entry),
    .scan_we    (scan_we),
    .scan_wdata (scan_wdata),
    .rd_idx     (tbl_ridx),
    .rd_data    (rd_ent)
  );

  eoi_scan #(.N(NPINS), .THRESH(THRESH)) u_scan (
    .clk        (clk),
    .rst        (rst),
    .eoi_valid  (eoi_valid),
    .eoi_ready  (eoi_ready),
    .eoi_vec    (eoi_vector),
    .pend       (pend_q),
    .busy       (busy_i),
    .scan_idx   (scan_idx),
    .scan_entry (scan_entry),
    .scan_we    (scan_we),
    .scan_wdata (scan_wdata),
    .imm_req    (imm_req),
    .arm_req    (arm_req)
  );

  eoi_timer #(.DELAY(DELAY)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .arm    (arm_req),
    .expire (tmr_expire)
  );

  // R8: every pulse has a cause one cycle earlier, and two causes give one pulse
  p_req_cause_r8: assert property (@(posedge clk) disable iff (rst)
    service_req |-> $past(imm_req || tmr_expire));

  // R5: a deferral never comes with an immediate request in the same slot
  p_defer_not_immediate_r5: assert property (@(posedge clk) disable iff (rst)
    arm_req |-> !imm_req);
endmodule

// File: tb/sim_eoi_storm_ctl.sv
`timescale 1ns/1ps
module sim_eoi_storm_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 24;
  localparam int THR = 4;
  localparam int DLY = 60;
  localparam int IW  = $clog2(NP);

  logic clk = 0, rst = 1;
  logic eoi_valid = 0;
  logic eoi_ready;
  logic [7:0] eoi_vector = 0;
  logic [NP-1:0] pend_in = 0;
  logic tbl_we = 0;
  logic [IW-1:0] tbl_widx = 0;
  logic [16:0] tbl_wdata = 0;
  logic [IW-1:0] tbl_ridx = 0;
  logic [16:0] tbl_rdata;
  logic busy, service_req;

  eoi_storm_ctl #(.NPINS(NP), .THRESH(THR), .DELAY(DLY)) u0 (
    .clk(clk), .rst(rst), .eoi_valid(eoi_valid), .eoi_ready(eoi_ready),
    .eoi_vector(eoi_vector), .pend_in(pend_in), .tbl_we(tbl_we),
    .tbl_widx(tbl_widx), .tbl_wdata(tbl_wdata), .tbl_ridx(tbl_ridx),
    .tbl_rdata(tbl_rdata), .busy(busy), .service_req(service_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model
  logic [16:0] m_tbl [NP];
  int m_cnt [256];
  bit m_armed = 0;
  longint m_due = 0;
  longint cyc = 0;
  longint scan_base = 0;
  bit scan_on = 0;
  bit ev_imm [NP];
  bit ev_arm [NP];
  bit last_busy = 0;
  int merged = 0;
  string tag_imm = "R4";
  string tag_tmr = "R5";

  function automatic logic [16:0] mk(bit lvl, bit msk, bit rirr, logic [7:0] v);
    return {msk, lvl, rirr, 6'b0, v};
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    int k;
    bit imm, arm, tmr, exp_busy;
    string lbl;
    @(posedge clk);
    cyc++;
    imm = 0; arm = 0;
    k = int'(cyc - scan_base - 1);
    if (scan_on && k >= 0 && k < NP) begin imm = ev_imm[k]; arm = ev_arm[k]; end
    tmr = m_armed && (m_due == cyc);
    if (tmr) m_armed = 0;
    if (arm && (!m_armed || cyc + DLY < m_due)) begin m_armed = 1; m_due = cyc + DLY; end
    exp_busy = scan_on && (cyc - scan_base) >= 0 && (cyc - scan_base) < NP;
    if (scan_on && k == NP - 1) scan_on = 0;
    if (imm && tmr) merged++;
    #1;
    if (imm && tmr) lbl = "R8";
    else if (tmr)   lbl = tag_tmr;
    else if (imm)   lbl = tag_imm;
    else            lbl = "R2";
    chk({lbl, " service_req"}, service_req, imm || tmr);
    chk("R9 busy", busy, exp_busy);
    last_busy = exp_busy;
  endtask

  task automatic eoi_start(logic [7:0] v);
    int c;
    chk("R9 ready before accept", eoi_ready, 1);
    eoi_valid = 1; eoi_vector = v;
    for (int k = 0; k < NP; k++) begin
      logic [16:0] e;
      e = m_tbl[k];
      ev_imm[k] = 0; ev_arm[k] = 0;
      if (e[15] && e[7:0] == v && e[14]) begin
        m_tbl[k][14] = 1'b0;
        if (!e[16] && pend_in[k]) begin
          c = m_cnt[v] + 1;
          if (c >= THR) begin m_cnt[v] = 0; ev_arm[k] = 1; end
          else begin m_cnt[v] = c; ev_imm[k] = 1; end
        end else begin
          m_cnt[v] = 0;
        end
      end
    end
    scan_base = cyc + 1;
    scan_on = 1;
    step();
    eoi_valid = 0;
    chk("R9 ready low in scan", eoi_ready, 0);
  endtask

  task automatic wait_idle();
    while (scan_on) step();
  endtask

  task automatic eoi(logic [7:0] v);
    eoi_start(v);
    wait_idle();
  endtask

  task automatic wr(int idx, logic [16:0] d);
    bit was_busy;
    was_busy = last_busy;
    tbl_we = 1; tbl_widx = IW'(idx); tbl_wdata = d;
    step();
    tbl_we = 0;
    if (!was_busy && idx < NP) m_tbl[idx] = d;
  endtask

  task automatic rd_chk(string tag, int idx);
    tbl_ridx = IW'(idx);
    step();
    chk(tag, tbl_rdata, m_tbl[idx]);
  endtask

  task automatic rd_all(string tag);
    for (int i = 0; i < NP; i++) rd_chk(tag, i);
  endtask

  task automatic flush_timer();
    while (m_armed) step();
    repeat (2) step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    longint a1;
    seed = $urandom(32'd20240517);
    for (int i = 0; i < NP; i++) m_tbl[i] = 17'h10000;
    for (int v = 0; v < 256; v++) m_cnt[v] = 0;

    // R1: reset state
    rst = 1;
    repeat (3) step();
    rst = 0;
    step();
    chk("R1 ready", eoi_ready, 1);
    chk("R1 service_req", service_req, 0);
    rd_all("R1 table reset");
    pend_in = '1;
    step();
    eoi(8'h00);
    rd_all("R1 table after eoi on reset state");

    // R2/R3/R4: matching rules and the clear of the wait flag
    wr(0,  mk(1, 0, 1, 8'h31));
    wr(1,  mk(0, 0, 1, 8'h31));
    wr(2,  mk(1, 0, 1, 8'h32));
    wr(3,  mk(1, 0, 0, 8'h31));
    wr(5,  mk(1, 1, 1, 8'h31));
    wr(23, mk(1, 0, 1, 8'h31));
    eoi(8'h31);
    rd_chk("R3 entry0 cleared", 0);
    rd_chk("R2 edge entry kept", 1);
    rd_chk("R2 other vector kept", 2);
    rd_chk("R2 idle entry kept", 3);
    rd_chk("R3 masked entry cleared", 5);
    rd_chk("R3 last entry cleared", 23);

    // R5: storm on vector 0x40, entry 7
    tag_imm = "R4";
    for (int n = 0; n < THR; n++) begin
      wr(7, mk(1, 0, 1, 8'h40));
      eoi(8'h40);
    end
    tag_tmr = "R5";
    flush_timer();
    // after the deferral the counter restarts: next is immediate
    tag_imm = "R5";
    wr(7, mk(1, 0, 1, 8'h40));
    eoi(8'h40);

    // R11: a different vector keeps its own count
    tag_imm = "R11";
    wr(8, mk(1, 0, 1, 8'h41));
    eoi(8'h41);
    wr(7, mk(1, 0, 1, 8'h40));
    eoi(8'h40);
    wr(8, mk(1, 0, 1, 8'h41));
    eoi(8'h41);
    flush_timer();

    // R6: a not-pending delivery resets the counter
    tag_imm = "R6";
    pend_in[7] = 0;
    wr(7, mk(1, 0, 1, 8'h40));
    eoi(8'h40);
    pend_in[7] = 1;
    for (int n = 0; n < THR - 1; n++) begin
      wr(7, mk(1, 0, 1, 8'h40));
      eoi(8'h40);
    end
    flush_timer();

    // R7: a second arm while armed keeps the earlier expiry
    tag_imm = "R4";
    for (int n = 0; n < THR - 1; n++) begin
      wr(12, mk(1, 0, 1, 8'h60));
      wr(13, mk(1, 0, 1, 8'h61));
      eoi(8'h60);
      eoi(8'h61);
    end
    wr(12, mk(1, 0, 1, 8'h60));
    wr(13, mk(1, 0, 1, 8'h61));
    tag_tmr = "R7";
    eoi(8'h60);
    eoi(8'h61);
    flush_timer();
    repeat (DLY) step();

    // R8: expiry and immediate on the same edge
    tag_tmr = "R5";
    for (int n = 0; n < THR - 1; n++) begin
      wr(14, mk(1, 0, 1, 8'h70));
      eoi(8'h70);
    end
    wr(14, mk(1, 0, 1, 8'h70));
    wr(10, mk(1, 0, 1, 8'h71));
    eoi_start(8'h70);
    a1 = scan_base;
    wait_idle();
    while (cyc < a1 + 63) step();
    eoi(8'h71);
    flush_timer();
    chk("R8 merged edge reached", merged, 1);

    // R10: writes during a scan and out-of-range writes are ignored
    wr(4, mk(1, 0, 1, 8'h99));
    eoi_start(8'h12);
    wr(4, mk(0, 1, 0, 8'h55));
    wr(6, mk(0, 1, 0, 8'h55));
    wait_idle();
    wr(NP, mk(0, 0, 0, 8'h77));
    wr(NP + 3, mk(0, 0, 0, 8'h77));
    rd_chk("R10 write in scan ignored", 4);
    rd_chk("R10 write in scan ignored", 6);
    rd_all("R10 out of range write ignored");

    // random phase
    tag_imm = "R4";
    tag_tmr = "R5";
    for (int it = 0; it < 30; it++) begin
      for (int j = 0; j < 3; j++) begin
        int idx;
        idx = int'($urandom % NP);
        wr(idx, mk(($urandom % 4) != 0, ($urandom % 4) == 0, ($urandom % 4) != 0,
                   8'h50 + 8'($urandom % 4)));
      end
      pend_in = NP'($urandom);
      step();
      eoi(8'h50 + 8'($urandom % 4));
      for (int j = 0; j < 3; j++) rd_chk("R3 random table", int'($urandom % NP));
    end
    flush_timer();
    rd_all("R2 final table");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule